// File: doc/BRIEF.md
# I2C Master SCL Clock Generator

This block produces the serial clock of an I2C master from the system clock. A 12-bit divider value and two mode bits pick one of three waveforms: a standard-speed clock whose low and high halves are equal, and two fast-speed clocks whose low:high ratios are 2:1 and 16:9. Each mode clamps the divider to its own minimum. A rise-time register loads the high-phase counter at a nonzero start value. This shortens the counted part of the high phase and makes up for the cycles SCL needs to climb.

The line is open drain. The block never drives SCL high. It only asserts `scl_drive_low` and releases the line otherwise. After each release it watches the synchronised line. The high-phase count starts only once SCL is seen high, so a slave that holds the clock low lengthens the period. The byte engine gets three one-cycle strobes: one when SCL is seen rising, one at the data sample point in the middle of the high phase, and one in the cycle before SCL is pulled low. The divider, mode and rise registers can be written only while the block is disabled. The block runs periods while both `enable` and `run` are high. All pins are plain control and status, with no streaming handshake.

Top module: `i2c_scl_gen`

## Requirements
- R1: After reset, and in the cycle after any clock edge that sees `enable` low, `scl_drive_low` is 0. The strobes are 0 while disabled.
- R2: Configuration writes (`cfg_we` high at a clock edge) use the following map. Address 0 holds divider bits [7:0]. Address 1 holds divider bits [11:8] in data bits [3:0], the duty select in bit 6 and the fast select in bit 7. Address 2 holds the rise value in data bits [5:0]. The reset value of all of these is 0.
- R3: In standard mode (fast select 0), with c = max(divider, 4), SCL is driven low for c cycles and the nominal high count H is c.
- R4: In fast mode with duty select 0, with c = max(divider, 1), SCL is low for 2c cycles and H = c.
- R5: In fast mode with duty select 1, with c = max(divider, 1), SCL is low for 16c cycles and H = 9c.
- R6: The duty select has no effect in standard mode.
- R7: Let k be the number of cycles another device keeps SCL low after release, and R the rise value. SCL stays released for k + 4 + max(H − R, 0) cycles before it is driven low again. With R ≥ H the counted high part collapses to a single cycle.
- R8: Number the released cycles of a period from 1. `scl_rise` pulses in cycle k + 3. `scl_sample` pulses in cycle k + 4 + (m − R), where m = floor((R + H) / 2) if H > R and m = R otherwise. `scl_fall` pulses in the last released cycle, and SCL is driven low in the next cycle.
- R9: From idle with `enable` high, `scl_fall` pulses in the cycle `run` is high, and SCL goes low in the next cycle. If `run` is low at the end of a high phase, the line stays released and no further `scl_fall` occurs.
- R10: Configuration writes made while `enable` is high are ignored, and the running waveform keeps its timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Block enable; low forces idle and locks nothing |
| run | input | 1 | Request to keep generating clock periods |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | Configuration register select (0, 1, 2) |
| cfg_wdata | input | 8 | Configuration write data |
| scl_in | input | 1 | Sampled level of the SCL line |
| scl_drive_low | output | 1 | Open-drain pull-down enable for SCL |
| scl_rise | output | 1 | One-cycle strobe: SCL seen high after release |
| scl_fall | output | 1 | One-cycle strobe: SCL is pulled low next cycle |
| scl_sample | output | 1 | One-cycle strobe at the mid-high sample point |

## Verification
The bench targets the clamp boundaries: a divider of 0 in both fast modes and a divider of 2 in standard mode. A design that skips or mixes up the clamps would produce a 0-length or a 1:1 low phase. It also checks a rise value of at least H, where a counter that compared only for equality would wrap and stretch the high phase by thousands of cycles. A slave stall of several cycles is injected to confirm that the high count waits for the line and does not time out from the release. The bench then writes registers while running and checks that the period does not change. It also covers the duty select set in standard mode, a divider that uses the upper nibble, and `run` or `enable` dropped mid-period. A design that ignored `run` would keep producing falls.

// File: rtl/i2c_scl_pkg.sv
package i2c_scl_pkg;

  typedef enum logic [1:0] {
    SCL_IDLE,
    SCL_LOW,
    SCL_WAIT,
    SCL_HIGH
  } scl_state_e;

  typedef enum logic [1:0] {
    MODE_STD,
    MODE_FAST_2,
    MODE_FAST_169
  } scl_mode_e;

  localparam logic [1:0] CFG_DIV_LO = 2'd0;
  localparam logic [1:0] CFG_DIV_HI = 2'd1;
  localparam logic [1:0] CFG_RISE   = 2'd2;

  localparam int HI_DUTY_BIT = 6;
  localparam int HI_FAST_BIT = 7;

endpackage

// File: rtl/scl_cfg_regs.sv
module scl_cfg_regs
  import i2c_scl_pkg::*;
#(
  parameter int CCR_W  = 12,
  parameter int RISE_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [7:0]        wr_data,
  output logic [CCR_W-1:0]  ccr,
  output logic              fast,
  output logic              duty,
  output logic [RISE_W-1:0] rise
);

  localparam int HI_W = CCR_W - 8;

  logic [7:0]      ccr_lo_q;
  logic [HI_W-1:0] ccr_hi_q;
  logic            fast_q;
  logic            duty_q;
  logic [RISE_W-1:0] rise_q;

  // writes only land while the block is disabled
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ccr_lo_q <= '0;
      ccr_hi_q <= '0;
      fast_q   <= 1'b0;
      duty_q   <= 1'b0;
      rise_q   <= '0;
    end else if (wr_en && !enable) begin
      case (wr_addr)
        CFG_DIV_LO: ccr_lo_q <= wr_data;
        CFG_DIV_HI: begin
          ccr_hi_q <= wr_data[HI_W-1:0];
          duty_q   <= wr_data[HI_DUTY_BIT];
          fast_q   <= wr_data[HI_FAST_BIT];
        end
        CFG_RISE:   rise_q <= wr_data[RISE_W-1:0];
        default:    ;
      endcase
    end
  end

  assign ccr  = {ccr_hi_q, ccr_lo_q};
  assign fast = fast_q;
  assign duty = duty_q;
  assign rise = rise_q;

  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    enable |=> $stable({ccr_lo_q, ccr_hi_q, fast_q, duty_q, rise_q})); // R10

endmodule

// File: rtl/scl_phase_calc.sv
module scl_phase_calc
  import i2c_scl_pkg::*;
#(
  parameter int CCR_W  = 12,
  parameter int RISE_W = 6,
  parameter int PER_W  = CCR_W + 4
) (
  input  logic [CCR_W-1:0]  ccr,
  input  logic              fast,
  input  logic              duty,
  input  logic [RISE_W-1:0] rise,
  output logic [PER_W-1:0]  low_len,
  output logic [PER_W-1:0]  high_len,
  output logic [PER_W-1:0]  mid_pt,
  output logic [PER_W-1:0]  rise_pre
);

  localparam logic [CCR_W-1:0] STD_MIN  = CCR_W'(4);
  localparam logic [CCR_W-1:0] FAST_MIN = CCR_W'(1);

  scl_mode_e        mode;
  logic [PER_W-1:0] c_std;
  logic [PER_W-1:0] c_fast;
  logic [PER_W:0]   mid_sum;

  always_comb begin
    if (!fast)     mode = MODE_STD;
    else if (duty) mode = MODE_FAST_169;
    else           mode = MODE_FAST_2;
  end

  assign c_std  = PER_W'((ccr < STD_MIN)  ? STD_MIN  : ccr);
  assign c_fast = PER_W'((ccr < FAST_MIN) ? FAST_MIN : ccr);

  always_comb begin
    case (mode)
      MODE_FAST_2: begin
        low_len  = c_fast << 1;
        high_len = c_fast;
      end
      MODE_FAST_169: begin
        low_len  = c_fast << 4;
        high_len = (c_fast << 3) + c_fast;
      end
      default: begin
        low_len  = c_std;
        high_len = c_std;
      end
    endcase
  end

  assign rise_pre = PER_W'(rise);
  assign mid_sum  = {1'b0, rise_pre} + {1'b0, high_len};
  assign mid_pt   = (high_len > rise_pre) ? mid_sum[PER_W:1] : rise_pre;

endmodule

// File: rtl/scl_timer.sv
module scl_timer
  import i2c_scl_pkg::*;
#(
  parameter int PER_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             run,
  input  logic             scl_in,
  input  logic [PER_W-1:0] low_len,
  input  logic [PER_W-1:0] high_len,
  input  logic [PER_W-1:0] mid_pt,
  input  logic [PER_W-1:0] rise_pre,
  output logic             scl_drive_low,
  output logic             scl_rise,
  output logic             scl_fall,
  output logic             scl_sample
);

  localparam logic [PER_W-1:0] ONE = PER_W'(1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   scl_hi;
  scl_state_e             st;
  logic [PER_W-1:0]       cnt;
  logic                   drv_q;
  logic                   high_done;

  // line synchroniser, idles at the released (high) level
  for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q[0] <= 1'b1;
        else        sync_q[0] <= scl_in;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q[g] <= 1'b1;
        else        sync_q[g] <= sync_q[g-1];
      end
    end
  end

  assign scl_hi    = sync_q[SYNC_STAGES-1];
  assign high_done = (st == SCL_HIGH) && (cnt >= high_len);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= SCL_IDLE;
      cnt   <= '0;
      drv_q <= 1'b0;
    end else if (!enable) begin
      st    <= SCL_IDLE;
      cnt   <= '0;
      drv_q <= 1'b0;
    end else begin
      case (st)
        SCL_IDLE: if (run) begin
          st    <= SCL_LOW;
          cnt   <= ONE;
          drv_q <= 1'b1;
        end
        SCL_LOW: begin
          if (cnt >= low_len) begin
            st    <= SCL_WAIT;
            drv_q <= 1'b0;
          end else begin
            cnt <= cnt + ONE;
          end
        end
        SCL_WAIT: if (scl_hi) begin
          st  <= SCL_HIGH;
          cnt <= rise_pre;
        end
        default: begin
          if (high_done) begin
            if (run) begin
              st    <= SCL_LOW;
              cnt   <= ONE;
              drv_q <= 1'b1;
            end else begin
              st <= SCL_IDLE;
            end
          end else begin
            cnt <= cnt + ONE;
          end
        end
      endcase
    end
  end

  assign scl_drive_low = drv_q;
  assign scl_fall   = enable && run && ((st == SCL_IDLE) || high_done);
  assign scl_rise   = enable && (st == SCL_WAIT) && scl_hi;
  assign scl_sample = enable && (st == SCL_HIGH) && (cnt == mid_pt);

  AST_OFF_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !scl_drive_low); // R1
  AST_FALL_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
    scl_fall |=> scl_drive_low); // R8
  AST_RISE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    scl_rise |-> !scl_drive_low); // R8
  AST_NO_FALL_NORUN: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> !scl_fall); // R9
  AST_LOW_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (st == SCL_LOW) |-> (cnt >= ONE && cnt <= low_len)); // R3
  AST_EDGE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({scl_rise, scl_fall})); // R8

endmodule

// File: rtl/i2c_scl_gen.sv
module i2c_scl_gen
  import i2c_scl_pkg::*;
#(
  parameter int CCR_W       = 12,
  parameter int RISE_W      = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       enable,
  input  logic       run,
  input  logic       cfg_we,
  input  logic [1:0] cfg_addr,
  input  logic [7:0] cfg_wdata,
  input  logic       scl_in,
  output logic       scl_drive_low,
  output logic       scl_rise,
  output logic       scl_fall,
  output logic       scl_sample
);

  localparam int PER_W = CCR_W + 4;

  logic [CCR_W-1:0]  ccr;
  logic              fast;
  logic              duty;
  logic [RISE_W-1:0] rise;
  logic [PER_W-1:0]  low_len;
  logic [PER_W-1:0]  high_len;
  logic [PER_W-1:0]  mid_pt;
  logic [PER_W-1:0]  rise_pre;

  scl_cfg_regs #(.CCR_W(CCR_W), .RISE_W(RISE_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .enable(enable),
    .wr_en(cfg_we), .wr_addr(cfg_addr), .wr_data(cfg_wdata),
    .ccr(ccr), .fast(fast), .duty(duty), .rise(rise)
  );

  scl_phase_calc #(.CCR_W(CCR_W), .RISE_W(RISE_W), .PER_W(PER_W)) u_calc (
    .ccr(ccr), .fast(fast), .duty(duty), .rise(rise),
    .low_len(low_len), .high_len(high_len), .mid_pt(mid_pt), .rise_pre(rise_pre)
  );

  scl_timer #(.PER_W(PER_W), .SYNC_STAGES(SYNC_STAGES)) u_timer (
    .clk(clk), .rst_n(rst_n), .enable(enable), .run(run), .scl_in(scl_in),
    .low_len(low_len), .high_len(high_len), .mid_pt(mid_pt), .rise_pre(rise_pre),
    .scl_drive_low(scl_drive_low), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .scl_sample(scl_sample)
  );

  AST_STD_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
    (!fast && enable) |-> (low_len >= PER_W'(4))); // R3

endmodule

// File: tb/tb_i2c_scl_gen.sv
`timescale 1ns/1ps
module tb_i2c_scl_gen;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       enable = 1'b0;
  logic       run = 1'b0;
  logic       cfg_we = 1'b0;
  logic [1:0] cfg_addr = 2'd0;
  logic [7:0] cfg_wdata = 8'd0;
  logic       hold = 1'b0;
  logic       scl_in;
  logic       scl_drive_low, scl_rise, scl_fall, scl_sample;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  assign scl_in = !(scl_drive_low || hold);

  i2c_scl_gen dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .run(run),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .scl_in(scl_in), .scl_drive_low(scl_drive_low), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .scl_sample(scl_sample)
  );

  typedef struct packed {
    logic [11:0] ccr;
    logic        fast;
    logic        duty;
    logic [5:0]  rise;
    logic [15:0] lo;
    logic [15:0] rel;
    logic [15:0] samp;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{12'd10,  1'b0, 1'b0, 6'd0,  16'd10,  16'd14,  16'd9},
    '{12'd2,   1'b0, 1'b0, 6'd2,  16'd4,   16'd6,   16'd5},
    '{12'd5,   1'b1, 1'b0, 6'd3,  16'd10,  16'd6,   16'd5},
    '{12'd0,   1'b1, 1'b0, 6'd0,  16'd2,   16'd5,   16'd4},
    '{12'd2,   1'b1, 1'b1, 6'd5,  16'd32,  16'd17,  16'd10},
    '{12'd0,   1'b1, 1'b1, 6'd20, 16'd16,  16'd4,   16'd4},
    '{12'd300, 1'b0, 1'b0, 6'd0,  16'd300, 16'd304, 16'd154},
    '{12'd6,   1'b0, 1'b1, 6'd1,  16'd6,   16'd9,   16'd6}
  };

  // period monitor, sampled away from the active edge
  int n_lows = 0, n_falls = 0;
  int lo_cnt = 0, hi_cnt = 0, last_lo = 0;
  int rise_idx = 0, samp_idx = 0, fall_idx = 0;
  int lat_hi = 0, lat_rise = 0, lat_samp = 0, lat_fall = 0;
  bit prev_dl = 1'b0;

  always @(negedge clk) begin
    if (scl_drive_low) begin
      if (!prev_dl) begin
        n_lows++;
        lat_hi = hi_cnt; lat_rise = rise_idx; lat_samp = samp_idx; lat_fall = fall_idx;
        lo_cnt = 0;
      end
      lo_cnt++;
    end else begin
      if (prev_dl) begin
        last_lo = lo_cnt; hi_cnt = 0; rise_idx = 0; samp_idx = 0; fall_idx = 0;
      end
      hi_cnt++;
      if (scl_rise)   rise_idx = hi_cnt;
      if (scl_sample) samp_idx = hi_cnt;
      if (scl_fall)   fall_idx = hi_cnt;
    end
    if (scl_fall) n_falls++;
    prev_dl = scl_drive_low;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk); #1;
  endtask

  task automatic write_reg(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic configure(input logic [11:0] c, input logic f, input logic du, input logic [5:0] r);
    write_reg(2'd0, c[7:0]);
    write_reg(2'd1, {f, du, 2'b00, c[11:8]});
    write_reg(2'd2, {2'b00, r});
  endtask

  task automatic wait_lows(input int target);
    while (n_lows < target) tick();
  endtask

  function automatic string mode_tag(input logic f, input logic du);
    if (f) return du ? "R5" : "R4";
    return du ? "R6" : "R3";
  endfunction

  task automatic stop_and_disable();
    @(negedge clk); run = 1'b0;
    repeat (700) @(negedge clk);
    enable = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int n0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    tick();
    // R1 reset state
    check(scl_drive_low == 1'b0, "R1 reset drive", scl_drive_low, 0);
    check({scl_rise, scl_fall, scl_sample} == 3'b000, "R1 reset strobes",
          {scl_rise, scl_fall, scl_sample}, 0);
    run = 1'b1;
    repeat (20) tick();
    check(n_lows == 0 && scl_drive_low == 1'b0, "R1 disabled stays released", n_lows, 0);
    run = 1'b0;

    // table walk: R2 field positions, R3..R6 shapes, R7 release, R8 strobes
    for (int i = 0; i < NV; i++) begin
      configure(VECS[i].ccr, VECS[i].fast, VECS[i].duty, VECS[i].rise);
      @(negedge clk);
      enable = 1'b1; run = 1'b1;
      n0 = n_lows;
      wait_lows(n0 + 2);
      check(last_lo == int'(VECS[i].lo), mode_tag(VECS[i].fast, VECS[i].duty), last_lo, int'(VECS[i].lo));
      check(lat_hi == int'(VECS[i].rel), "R7 released length", lat_hi, int'(VECS[i].rel));
      check(lat_rise == 3, "R8 rise strobe slot", lat_rise, 3);
      check(lat_samp == int'(VECS[i].samp), "R8 sample strobe slot", lat_samp, int'(VECS[i].samp));
      check(lat_fall == int'(VECS[i].rel), "R8 fall strobe slot", lat_fall, int'(VECS[i].rel));
      stop_and_disable();
    end

    // R7 slave stretch of 5 cycles: std c=8, rise 2
    configure(12'd8, 1'b0, 1'b0, 6'd2);
    @(negedge clk);
    enable = 1'b1; run = 1'b1;
    n0 = n_lows;
    wait_lows(n0 + 1);
    hold = 1'b1;
    do @(negedge clk); while (scl_drive_low);
    repeat (5) @(negedge clk);
    hold = 1'b0;
    wait_lows(n0 + 2);
    check(lat_hi == 15, "R7 stretched release", lat_hi, 15);
    check(lat_rise == 8, "R8 stretched rise slot", lat_rise, 8);
    check(lat_samp == 12, "R8 stretched sample slot", lat_samp, 12);
    stop_and_disable();

    // R10 writes while enabled are ignored
    configure(12'd10, 1'b0, 1'b0, 6'd0);
    @(negedge clk);
    enable = 1'b1; run = 1'b1;
    n0 = n_lows;
    wait_lows(n0 + 1);
    write_reg(2'd0, 8'd40);
    write_reg(2'd1, 8'h80);
    write_reg(2'd2, 8'd7);
    n0 = n_lows;
    wait_lows(n0 + 2);
    check(last_lo == 10, "R10 low unchanged", last_lo, 10);
    check(lat_hi == 14, "R10 release unchanged", lat_hi, 14);
    stop_and_disable();

    // R2 write while disabled takes effect
    write_reg(2'd0, 8'd40);
    @(negedge clk);
    enable = 1'b1; run = 1'b1;
    n0 = n_lows;
    wait_lows(n0 + 2);
    check(last_lo == 40, "R2 low after write", last_lo, 40);
    check(lat_hi == 44, "R2 release after write", lat_hi, 44);

    // R9 run dropped: current period ends, no further falls
    begin
      int nl, nf;
      n0 = n_lows;
      wait_lows(n0 + 1);
      run = 1'b0;
      nl = n_lows; nf = n_falls;
      repeat (200) tick();
      check(n_lows == nl, "R9 no new low", n_lows, nl);
      check(n_falls == nf, "R9 no fall strobe", n_falls, nf);
      check(scl_drive_low == 1'b0, "R9 released idle", scl_drive_low, 0);
    end

    // R9 start from idle
    @(negedge clk);
    run = 1'b1;
    #1;
    check(scl_fall == 1'b1 && scl_drive_low == 1'b0, "R9 idle fall strobe", scl_fall, 1);
    tick();
    check(scl_drive_low == 1'b1, "R9 low follows", scl_drive_low, 1);

    // R1 enable dropped mid-low
    @(negedge clk);
    enable = 1'b0;
    tick();
    check(scl_drive_low == 1'b0, "R1 release on disable", scl_drive_low, 0);
    check({scl_rise, scl_fall, scl_sample} == 3'b000, "R1 strobes off",
          {scl_rise, scl_fall, scl_sample}, 0);
    run = 1'b0;

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule